// File: doc/BRIEF.md
# Register-Polled Display Pixel Port

This block lets a host processor or a DMA engine fetch finished pixels by reading one register, rather than having a display pipeline drain a hardware FIFO. Composited pixels arrive on a valid/ready stream and are held in a small pixel FIFO. The flow of pixels is gated per line and per frame. A write to the port register with the frame-start bit set opens a frame. A write with the line-start bit set lets exactly one line of pixels in.

A read of the port returns the oldest pixel together with three flags: data present, FIFO empty and line fully read. In the packed mode, a read returns two pixels reduced to 16 bits each and carries no flags. A one-shot mode stops the block after a single frame. If the register output is not selected, pixels leave through an ordinary valid/ready display output instead.

Control bits, line width and frame height are taken from configuration inputs at each frame start. They are held fixed for the rest of that frame.

Top module: `regpoll_disp_port`

## Requirements
- R1: After reset, `src_ready` and `disp_valid` are 0 and `reg_rdata` reads 0.
- R2: A port write with bit 31 set (frame start) captures enable, one-shot, packing, register-output, width and height. With enable 0, no pixel is accepted afterwards. Configuration changes made during a frame have no effect until the next frame start.
- R3: A port write with bit 30 set (line start) opens a line only when a frame is running and either no line has yet been opened in this frame or the current line is fully read. Otherwise it is ignored. A single write with both bits set starts the frame and opens its first line.
- R4: Within an open line, exactly `width` pixels are accepted from the source. After that, `src_ready` stays 0 until an accepted line start.
- R5: In normal mode, `reg_rdata` carries the oldest pixel in bits 23:0, bit 24 = 1 (valid), bit 25 = 0, bit 26 = line-fully-read flag and bits 31:27 = 0. A read pops exactly one pixel.
- R6: A normal-mode read with the FIFO empty returns bit 24 = 0, bit 25 = 1 and bits 23:0 = 0, and pops nothing.
- R7: The line-fully-read flag (bit 26) becomes 1 once all `width` pixels of the line have been read. It returns to 0 on an accepted line start or on a frame start.
- R8: In packed mode, each pixel is cut to 5:6:5 as {R[7:3], G[7:2], B[7:3]}, with R = bits 23:16, G = bits 15:8 and B = bits 7:0. The older pixel goes in bits 15:0 and the next pixel in bits 31:16, and a read pops both. If only the line's last pixel remains, a read returns it in bits 15:0 with bits 31:16 = 0 and pops one. Any other read with fewer than two pixels buffered returns 0 and pops nothing.
- R9: In one-shot mode, the frame ends when the last pixel of line `height` leaves the FIFO. Line starts are then ignored until the next frame start.
- R10: In continuous mode, after `height` lines a line start begins the next frame without a new frame start.
- R11: With register output off, pixels leave on `disp_valid`/`disp_ready`, and port reads return 0 and pop nothing. With it on, `disp_valid` stays 0.
- R12: A frame start discards every pixel still buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Frame enable, captured at frame start |
| cfg_oneshot | input | 1 | Single-frame mode, captured at frame start |
| cfg_pack | input | 1 | Two-pixel 16-bit packed reads, captured at frame start |
| cfg_regout | input | 1 | Route pixels to the port register instead of the display output |
| cfg_width | input | 12 | Pixels per line |
| cfg_height | input | 12 | Lines per frame |
| src_valid | input | 1 | Source pixel valid |
| src_data | input | 24 | Source pixel, RGB 8:8:8 |
| src_ready | output | 1 | Block accepts a source pixel |
| reg_wr | input | 1 | Port register write strobe |
| reg_wdata | input | 32 | Write data: bit 31 frame start, bit 30 line start |
| reg_rd | input | 1 | Port register read strobe; pops at the clock edge |
| reg_rdata | output | 32 | Read word presented for the current cycle |
| disp_valid | output | 1 | Display output pixel valid |
| disp_data | output | 24 | Display output pixel |
| disp_ready | input | 1 | Display output consumer ready |

## Verification
The bench builds the block with the default FIFO depth of 4 and drives a line width of 3 and a frame height of 2 through the configuration inputs. With these values a whole line fits in the FIFO, so every line can be filled before it is read. The odd width leaves a single last pixel for a packed read, and the two-line frame lets both the one-shot stop and the continuous wrap occur within a few dozen cycles. A depth of 4 also lets a partly filled line be flushed by a frame start and then checked as empty.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
    localparam int DIM_W      = 12;
    localparam int PIX_W      = 24;
    localparam int BIT_VSTART = 31;
    localparam int BIT_HSTART = 30;

    typedef struct packed {
        logic             enable;
        logic             oneshot;
        logic             pack;
        logic             regout;
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
    } ctl_t;

    typedef enum logic {
        LN_WAIT = 1'b0,
        LN_RUN  = 1'b1
    } line_st_e;

    typedef struct packed {
        logic [4:0]       zero;
        logic             eol;
        logic             empty;
        logic             valid;
        logic [PIX_W-1:0] rgb;
    } stat_word_t;

    function automatic logic [15:0] to_rgb565(input logic [PIX_W-1:0] p);
        return {p[23:19], p[15:10], p[7:3]};
    endfunction
endpackage

// File: rtl/rpd_fifo.sv
module rpd_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 24
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic [1:0]                   pop_n,
    output logic [W-1:0]                 head0,
    output logic [W-1:0]                 head1,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];
    assign full  = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push) - CW'(pop_n);
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full)
        else $error("fifo push while full");

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_n) <= count)
        else $error("fifo pop beyond contents");
endmodule

// File: rtl/rpd_seq.sv
module rpd_seq
    import rpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vstart,
    input  logic       hstart,
    input  ctl_t       cfg,
    input  logic       accept,
    input  logic [1:0] pop_n,
    output ctl_t       ctl,
    output logic       active,
    output logic       line_open,
    output logic       eol,
    output logic       last_left
);
    localparam int CNT_W = DIM_W + 1;

    line_st_e         lstate;
    logic [DIM_W-1:0] in_cnt, out_cnt, line_idx;
    logic             last_line, hstart_ok, frame_done;

    assign last_line  = (line_idx == ctl.height - DIM_W'(1));
    assign eol        = (lstate == LN_RUN) && (out_cnt == ctl.width);
    assign line_open  = active && (lstate == LN_RUN) && (in_cnt < ctl.width);
    assign last_left  = (out_cnt == ctl.width - DIM_W'(1));
    assign hstart_ok  = hstart && active && ((lstate == LN_WAIT) || eol);
    assign frame_done = active && ctl.oneshot && last_line && (pop_n != 2'd0) &&
                        ((CNT_W'(out_cnt) + CNT_W'(pop_n)) == CNT_W'(ctl.width));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            active   <= 1'b0;
            lstate   <= LN_WAIT;
            in_cnt   <= '0;
            out_cnt  <= '0;
            line_idx <= '0;
        end else if (vstart) begin
            ctl      <= cfg;
            active   <= cfg.enable;
            lstate   <= (hstart && cfg.enable) ? LN_RUN : LN_WAIT;
            in_cnt   <= '0;
            out_cnt  <= '0;
            line_idx <= '0;
        end else if (hstart_ok) begin
            lstate  <= LN_RUN;
            in_cnt  <= '0;
            out_cnt <= '0;
            if (lstate == LN_RUN)
                line_idx <= last_line ? '0 : line_idx + DIM_W'(1);
        end else begin
            in_cnt  <= in_cnt + DIM_W'(accept);
            out_cnt <= out_cnt + DIM_W'(pop_n);
            if (frame_done) active <= 1'b0;
        end
    end

    p_in_bound_r4: assert property (@(posedge clk) disable iff (rst)
        in_cnt <= ctl.width)
        else $error("line accepted more pixels than its width");

    p_read_behind_r7: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= in_cnt)
        else $error("more pixels read than accepted");

    p_stop_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (!active && !vstart) |=> !active)
        else $error("frame restarted without frame start");
endmodule

// File: rtl/regpoll_disp_port.sv
module regpoll_disp_port
    import rpd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_enable,
    input  logic        cfg_oneshot,
    input  logic        cfg_pack,
    input  logic        cfg_regout,
    input  logic [11:0] cfg_width,
    input  logic [11:0] cfg_height,
    input  logic        src_valid,
    input  logic [23:0] src_data,
    output logic        src_ready,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    output logic        disp_valid,
    output logic [23:0] disp_data,
    input  logic        disp_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    ctl_t             cfg, ctl;
    logic             vstart, hstart, accept;
    logic             active, line_open, eol, last_left;
    logic [1:0]       pop_n, pk_n;
    logic [PIX_W-1:0] head0, head1;
    logic [CW-1:0]    count;
    logic             full, empty;
    stat_word_t       stat;

    assign cfg    = '{enable: cfg_enable, oneshot: cfg_oneshot, pack: cfg_pack,
                      regout: cfg_regout, width: cfg_width, height: cfg_height};
    assign vstart = reg_wr && reg_wdata[BIT_VSTART];
    assign hstart = reg_wr && reg_wdata[BIT_HSTART];
    assign empty  = (count == '0);

    assign src_ready = line_open && !full && !vstart;
    assign accept    = src_valid && src_ready;

    rpd_seq u_seq (
        .clk(clk), .rst(rst), .vstart(vstart), .hstart(hstart), .cfg(cfg),
        .accept(accept), .pop_n(pop_n), .ctl(ctl), .active(active),
        .line_open(line_open), .eol(eol), .last_left(last_left)
    );

    rpd_fifo #(.DEPTH(DEPTH), .W(PIX_W)) u_fifo (
        .clk(clk), .rst(rst), .flush(vstart), .push(accept), .push_data(src_data),
        .pop_n(pop_n), .head0(head0), .head1(head1), .count(count), .full(full)
    );

    always_comb begin
        if (count >= CW'(2))              pk_n = 2'd2;
        else if (!empty && last_left)     pk_n = 2'd1;
        else                              pk_n = 2'd0;
    end

    always_comb begin
        pop_n = 2'd0;
        if (ctl.regout) begin
            if (reg_rd) pop_n = ctl.pack ? pk_n : {1'b0, !empty};
        end else begin
            pop_n = {1'b0, disp_ready && !empty};
        end
    end

    always_comb begin
        stat.zero  = '0;
        stat.eol   = eol;
        stat.empty = empty;
        stat.valid = !empty;
        stat.rgb   = empty ? '0 : head0;
        if (!ctl.regout)
            reg_rdata = '0;
        else if (ctl.pack)
            case (pk_n)
                2'd2:    reg_rdata = {to_rgb565(head1), to_rgb565(head0)};
                2'd1:    reg_rdata = {16'h0000, to_rgb565(head0)};
                default: reg_rdata = '0;
            endcase
        else
            reg_rdata = stat;
    end

    assign disp_valid = !ctl.regout && !empty;
    assign disp_data  = head0;

    p_eol_drained_r7: assert property (@(posedge clk) disable iff (rst)
        eol |-> empty)
        else $error("line flagged read while pixels remain");

    p_hold_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.regout && !reg_rd && !vstart) |=> count >= $past(count))
        else $error("pixel lost without a register read");
endmodule

// File: tb/tb_regpoll_disp_port.sv
`timescale 1ns/1ps
module tb_regpoll_disp_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable, cfg_oneshot, cfg_pack, cfg_regout;
    logic [11:0] cfg_width, cfg_height;
    logic        src_valid;
    logic [23:0] src_data;
    logic        src_ready;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic        reg_rd;
    logic [31:0] reg_rdata;
    logic        disp_valid;
    logic [23:0] disp_data;
    logic        disp_ready;

    always #2 clk = ~clk;

    regpoll_disp_port #(.DEPTH(4)) dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_oneshot(cfg_oneshot),
        .cfg_pack(cfg_pack), .cfg_regout(cfg_regout), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .disp_valid(disp_valid),
        .disp_data(disp_data), .disp_ready(disp_ready)
    );

    int          checks = 0;
    int          errors = 0;
    logic [23:0] expq[$];
    logic [23:0] seed = 24'h1080F0;

    function automatic logic [15:0] b565(input logic [23:0] p);
        return {p[23:19], p[15:10], p[7:3]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic port_write(input logic v, input logic h);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = {v, h, 30'h0};
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    // driver: offers pixels and queues each accepted one as expected output
    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_valid = 1'b1;
            src_data  = seed;
            #1;
            for (int w = 0; w < 20 && !src_ready; w++) begin
                @(negedge clk);
                #1;
            end
            if (!src_ready) chk("R4 source stalled", 32'(src_ready), 32'd1);
            else expq.push_back(seed);
            seed = seed + 24'h0B1D27;
        end
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic ready_is(input string req, input logic val);
        @(negedge clk);
        #1;
        chk(req, 32'(src_ready), 32'(val));
    endtask

    // monitor side: each read compares against the scoreboard head
    task automatic rd_norm(input string req);
        logic [31:0] e;
        @(negedge clk);
        reg_rd = 1'b1;
        #1;
        if (expq.size() == 0) chk({req, " scoreboard empty"}, 32'd0, 32'd1);
        else begin
            e = {5'b0, 1'b0, 1'b0, 1'b1, expq.pop_front()};
            chk(req, reg_rdata, e);
        end
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [31:0] e);
        @(negedge clk);
        reg_rd = 1'b1;
        #1;
        chk(req, reg_rdata, e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_pack(input string req, input int n);
        logic [23:0] a, b;
        logic [31:0] e;
        a = expq.pop_front();
        if (n == 2) begin
            b = expq.pop_front();
            e = {b565(b), b565(a)};
        end else e = {16'h0000, b565(a)};
        rd_expect(req, e);
    endtask

    task automatic disp_take(input string req);
        @(negedge clk);
        disp_ready = 1'b1;
        #1;
        chk({req, " valid"}, 32'(disp_valid), 32'd1);
        chk({req, " data"}, 32'(disp_data), 32'(expq.pop_front()));
        @(negedge clk);
        disp_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_enable = 1'b1; cfg_oneshot = 1'b1; cfg_pack = 1'b0; cfg_regout = 1'b1;
        cfg_width = 12'd3; cfg_height = 12'd2;
        src_valid = 1'b0; src_data = '0; reg_wr = 1'b0; reg_wdata = '0;
        reg_rd = 1'b0; disp_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 src_ready", 32'(src_ready), 32'd0);
        chk("R1 disp_valid", 32'(disp_valid), 32'd0);
        chk("R1 reg_rdata", reg_rdata, 32'd0);

        // R3 line start before any frame start is ignored
        port_write(1'b0, 1'b1);
        ready_is("R3 hstart without frame", 1'b0);

        // one-shot frame, register output, normal reads
        port_write(1'b1, 1'b0);
        ready_is("R3 frame waits for line start", 1'b0);
        rd_expect("R6 empty read", 32'h0200_0000);
        port_write(1'b0, 1'b1);
        feed(3);
        ready_is("R4 line width reached", 1'b0);
        @(negedge clk); #1;
        chk("R11 disp quiet with register output", 32'(disp_valid), 32'd0);
        rd_norm("R5 line0 px0");
        rd_norm("R5 line0 px1");
        rd_norm("R5 line0 px2");
        rd_expect("R7 eol after full line", 32'h0600_0000);
        rd_expect("R6 no pop on empty", 32'h0600_0000);

        port_write(1'b0, 1'b1);
        feed(1);
        port_write(1'b0, 1'b1);   // mid-line line start: ignored
        feed(2);
        ready_is("R3 mid-line hstart ignored", 1'b0);
        rd_norm("R5 line1 px0");
        rd_norm("R5 line1 px1");
        rd_norm("R5 line1 px2");
        port_write(1'b0, 1'b1);
        ready_is("R9 one-shot stopped", 1'b0);

        // R2 disabled frame start
        cfg_enable = 1'b0;
        port_write(1'b1, 1'b0);
        port_write(1'b0, 1'b1);
        ready_is("R2 disabled frame", 1'b0);
        rd_expect("R7 eol cleared by frame start", 32'h0200_0000);
        cfg_enable = 1'b1;

        // continuous mode, combined frame+line start
        cfg_oneshot = 1'b0;
        port_write(1'b1, 1'b1);
        ready_is("R3 combined start opens line", 1'b1);
        feed(3);
        rd_norm("R5 cont line0 px0");
        rd_norm("R5 cont line0 px1");
        rd_norm("R5 cont line0 px2");
        port_write(1'b0, 1'b1);
        feed(3);
        rd_norm("R5 cont line1 px0");
        rd_norm("R5 cont line1 px1");
        rd_norm("R5 cont line1 px2");
        port_write(1'b0, 1'b1);
        ready_is("R10 next frame without frame start", 1'b1);
        cfg_pack = 1'b1;
        feed(3);
        rd_norm("R2 pack change mid-frame ignored px0");
        rd_norm("R2 pack change mid-frame ignored px1");
        rd_norm("R2 pack change mid-frame ignored px2");
        cfg_pack = 1'b0;

        // R12 flush on frame start
        port_write(1'b0, 1'b1);
        feed(2);
        expq.delete();
        port_write(1'b1, 1'b0);
        rd_expect("R12 buffered pixels discarded", 32'h0200_0000);

        // R8 packed reads
        cfg_pack = 1'b1;
        port_write(1'b1, 1'b1);
        feed(1);
        rd_expect("R8 single non-last pixel returns zero", 32'h0);
        feed(2);
        rd_pack("R8 two packed pixels", 2);
        rd_pack("R8 last pixel alone", 1);
        rd_expect("R8 packed empty read", 32'h0);
        cfg_pack = 1'b0;

        // R11 display output path
        cfg_regout = 1'b0;
        port_write(1'b1, 1'b1);
        feed(2);
        rd_expect("R11 register read zero", 32'h0);
        disp_take("R11 disp px0 kept after reg read");
        disp_take("R11 disp px1");
        @(negedge clk); #1;
        chk("R11 disp drained", 32'(disp_valid), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule